// File: doc/BRIEF.md
# Cascadable Magnitude Comparator

This block compares two unsigned words of equal, parameterised width and reports whether the first is below, equal to or above the second. It has three cascade inputs that carry the verdict of a less-significant stage. When the two words differ, the local verdict decides the outputs and the cascade inputs have no effect. When the words match, the outputs are a fixed decode of the cascade inputs. This decode also covers the patterns that are not one-hot, which a parallel expansion tree relies on.

For a serial chain, the lowest stage has its cascade inputs tied to "equal". Each higher stage takes the three outputs of the stage below it. A parameter can add one output register with a synchronous, active-high reset that clears all three outputs. With that parameter off, the block is purely combinational and the clock and reset pins only time the assertions.

Top module: `cascade_mag_cmp`

## Requirements
- R1: The word width is the parameter WIDTH, and the block compares correctly at width 5 and at width 4.
- R2: If a_word > b_word (unsigned), the outputs are {lt_out,eq_out,gt_out} = 3'b001, whatever the cascade inputs are.
- R3: If a_word < b_word (unsigned), the outputs are {lt_out,eq_out,gt_out} = 3'b100, whatever the cascade inputs are.
- R4: If the words are equal and the cascade inputs are one-hot, each output copies the cascade input of the same kind.
- R5: If the words are equal and eq_cin is 1, the outputs are 3'b010, even when lt_cin and gt_cin are also 1.
- R6: If the words are equal and all three cascade inputs are 0, the outputs are 3'b101.
- R7: If the words are equal, lt_cin and gt_cin are 1 and eq_cin is 0, the outputs are 3'b000.
- R8: After any change of a word or a cascade input, the outputs show the new verdict. This includes single-bit flips that move the verdict between equal, below and above.
- R9: With REGISTERED=1, the outputs show the verdict of the inputs sampled at the previous rising clock edge. If rst is 1 at an edge, the outputs become 3'b000 after that edge.
- R10: Two 4-bit stages in series form a correct 8-bit comparator. The low stage has its cascade inputs tied to lt=0, eq=1, gt=0, and the high stage takes the outputs of the low stage as its cascade inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register and the assertions |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a_word | input | WIDTH | First operand, unsigned |
| b_word | input | WIDTH | Second operand, unsigned |
| lt_cin | input | 1 | Cascade input: lower stage found a below b |
| eq_cin | input | 1 | Cascade input: lower stage found equality |
| gt_cin | input | 1 | Cascade input: lower stage found a above b |
| lt_out | output | 1 | a below b |
| eq_out | output | 1 | a equals b |
| gt_out | output | 1 | a above b |

## Verification
With the output register on, a reset and a new comparison can fall on the same clock edge. The bench provokes this by driving a word pair that gives "above" in the same cycle that rst is raised. It expects all-zero outputs after that edge, then 3'b001 one edge after rst falls. The combinational copy sees the same stimulus and must show 3'b001 throughout, so the two paths are judged against each other from one input sequence.

// File: rtl/cascade_mag_cmp.sv
module cascade_mag_cmp #(
  parameter int WIDTH      = 5,
  parameter bit REGISTERED = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_word,
  input  logic [WIDTH-1:0] b_word,
  input  logic             lt_cin,
  input  logic             eq_cin,
  input  logic             gt_cin,
  output logic             lt_out,
  output logic             eq_out,
  output logic             gt_out
);

  logic a_above, a_below, words_match;
  logic nx_lt, nx_eq, nx_gt;

  assign a_above     = a_word > b_word;
  assign a_below     = a_word < b_word;
  assign words_match = ~(a_above | a_below);

  assign nx_gt = a_above | (words_match & ~eq_cin & ~lt_cin);
  assign nx_lt = a_below | (words_match & ~eq_cin & ~gt_cin);
  assign nx_eq = words_match & eq_cin;

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          lt_out <= 1'b0;
          eq_out <= 1'b0;
          gt_out <= 1'b0;
        end else begin
          lt_out <= nx_lt;
          eq_out <= nx_eq;
          gt_out <= nx_gt;
        end
      end

      AST_REG_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ({lt_out, eq_out, gt_out} == $past({nx_lt, nx_eq, nx_gt}))); // R9
    end else begin : g_comb
      assign lt_out = nx_lt;
      assign eq_out = nx_eq;
      assign gt_out = nx_gt;
    end
  endgenerate

  AST_ABOVE_WINS: assert property (@(posedge clk) disable iff (rst)
    (a_word > b_word) |-> (nx_gt && !nx_lt && !nx_eq)); // R2
  AST_BELOW_WINS: assert property (@(posedge clk) disable iff (rst)
    (a_word < b_word) |-> (nx_lt && !nx_gt && !nx_eq)); // R3
  AST_EQ_CIN_DOMINATES: assert property (@(posedge clk) disable iff (rst)
    (a_word == b_word && eq_cin) |-> (nx_eq && !nx_lt && !nx_gt)); // R5
  AST_ALL_LOW_DECODE: assert property (@(posedge clk) disable iff (rst)
    (a_word == b_word && !lt_cin && !eq_cin && !gt_cin) |-> (nx_lt && nx_gt && !nx_eq)); // R6
  AST_BOTH_SIDES_DECODE: assert property (@(posedge clk) disable iff (rst)
    (a_word == b_word && lt_cin && !eq_cin && gt_cin) |-> (!nx_lt && !nx_gt && !nx_eq)); // R7
  AST_ONEHOT_PASS: assert property (@(posedge clk) disable iff (rst)
    (a_word == b_word && $onehot({lt_cin, eq_cin, gt_cin})) |->
      ({nx_lt, nx_eq, nx_gt} == {lt_cin, eq_cin, gt_cin})); // R4

endmodule

// File: tb/test_cascade_mag_cmp.sv
module test_cascade_mag_cmp;
  localparam int CLK_P = 10;
  localparam int W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a, b;
  logic l_in, e_in, g_in;
  logic c_lt, c_eq, c_gt, r_lt, r_eq, r_gt;
  logic [7:0] a8, b8;
  logic lo_lt, lo_eq, lo_gt, hi_lt, hi_eq, hi_gt;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  cascade_mag_cmp #(.WIDTH(W), .REGISTERED(1'b0)) i_cascade_mag_cmp (
    .clk(clk), .rst(rst), .a_word(a), .b_word(b), .lt_cin(l_in), .eq_cin(e_in),
    .gt_cin(g_in), .lt_out(c_lt), .eq_out(c_eq), .gt_out(c_gt));

  cascade_mag_cmp #(.WIDTH(W), .REGISTERED(1'b1)) i_reg (
    .clk(clk), .rst(rst), .a_word(a), .b_word(b), .lt_cin(l_in), .eq_cin(e_in),
    .gt_cin(g_in), .lt_out(r_lt), .eq_out(r_eq), .gt_out(r_gt));

  cascade_mag_cmp #(.WIDTH(4), .REGISTERED(1'b0)) i_lo (
    .clk(clk), .rst(rst), .a_word(a8[3:0]), .b_word(b8[3:0]), .lt_cin(1'b0), .eq_cin(1'b1),
    .gt_cin(1'b0), .lt_out(lo_lt), .eq_out(lo_eq), .gt_out(lo_gt));

  cascade_mag_cmp #(.WIDTH(4), .REGISTERED(1'b0)) i_hi (
    .clk(clk), .rst(rst), .a_word(a8[7:4]), .b_word(b8[7:4]), .lt_cin(lo_lt), .eq_cin(lo_eq),
    .gt_cin(lo_gt), .lt_out(hi_lt), .eq_out(hi_eq), .gt_out(hi_gt));

  function automatic logic [2:0] expect_of(input logic [W-1:0] x, input logic [W-1:0] y,
                                          input logic l, input logic e, input logic g);
    if (x > y) return 3'b001;
    if (x < y) return 3'b100;
    if (e) return 3'b010;
    if (!l && !g) return 3'b101;
    if (l && g) return 3'b000;
    return {l, 1'b0, g};
  endfunction

  task automatic chk(input string tag, input logic [2:0] got, input logic [2:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic drive(input string tag, input logic [W-1:0] x, input logic [W-1:0] y,
                       input logic l, input logic e, input logic g);
    @(negedge clk);
    a = x; b = y; l_in = l; e_in = e; g_in = g;
    #1 chk(tag, {c_lt, c_eq, c_gt}, expect_of(x, y, l, e, g));
    @(posedge clk);
    #1 chk({tag, " R9 reg"}, {r_lt, r_eq, r_gt}, expect_of(x, y, l, e, g));
  endtask

  task automatic t_reset;
    repeat (2) @(posedge clk);
    #1 chk("R9 reset", {r_lt, r_eq, r_gt}, 3'b000);
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic t_above;
    drive("R2 low bit", 5'b00001, 5'b00000, 1'b1, 1'b0, 1'b0);
    drive("R2 high bit", 5'b10000, 5'b01111, 1'b0, 1'b1, 1'b0);
    drive("R2 all cin low", 5'b11010, 5'b00011, 1'b0, 1'b0, 1'b0);
    drive("R1 max", 5'b11111, 5'b11110, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_below;
    drive("R3 low bit", 5'b00000, 5'b00001, 1'b0, 1'b0, 1'b1);
    drive("R3 mixed", 5'b01100, 5'b10110, 1'b0, 1'b1, 1'b0);
    drive("R3 both cin", 5'b00000, 5'b11111, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_onehot;
    drive("R4 lt", 5'b01101, 5'b01101, 1'b1, 1'b0, 1'b0);
    drive("R4 eq", 5'b00000, 5'b00000, 1'b0, 1'b1, 1'b0);
    drive("R4 gt", 5'b11111, 5'b11111, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_eq_dom;
    drive("R5 all high", 5'b01010, 5'b01010, 1'b1, 1'b1, 1'b1);
    drive("R5 gt too", 5'b01010, 5'b01010, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_odd_patterns;
    drive("R6 all low", 5'b11110, 5'b11110, 1'b0, 1'b0, 1'b0);
    drive("R7 both sides", 5'b01111, 5'b01111, 1'b1, 1'b0, 1'b1);
    drive("R7 diff overrides", 5'b01010, 5'b01111, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_flips;
    drive("R8 start eq", 5'b00100, 5'b00100, 1'b0, 1'b1, 1'b0);
    drive("R8 a bit up", 5'b00110, 5'b00100, 1'b0, 1'b1, 1'b0);
    drive("R8 b bit up", 5'b00110, 5'b01100, 1'b0, 1'b1, 1'b0);
    drive("R8 back eq", 5'b01100, 5'b01100, 1'b0, 1'b1, 1'b0);
    drive("R8 cin change", 5'b01100, 5'b01100, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reg_reset_collision;
    @(negedge clk);
    a = 5'b10011; b = 5'b01100; l_in = 1'b0; e_in = 1'b1; g_in = 1'b0; rst = 1'b1;
    #1 chk("R2 comb during reset", {c_lt, c_eq, c_gt}, 3'b001);
    @(posedge clk);
    #1 chk("R9 reset wins", {r_lt, r_eq, r_gt}, 3'b000);
    @(negedge clk) rst = 1'b0;
    @(posedge clk);
    #1 chk("R9 after reset", {r_lt, r_eq, r_gt}, 3'b001);
  endtask

  task automatic chain(input logic [7:0] x, input logic [7:0] y);
    logic [2:0] e;
    a8 = x; b8 = y;
    e = (x > y) ? 3'b001 : (x < y) ? 3'b100 : 3'b010;
    #1 chk("R10 chain / R1 width 4", {hi_lt, hi_eq, hi_gt}, e);
  endtask

  task automatic t_chain;
    chain(8'h5A, 8'h5A);
    chain(8'h5B, 8'h5A);
    chain(8'h4F, 8'h50);
    chain(8'hA0, 8'h0F);
    chain(8'h33, 8'h34);
  endtask

  initial begin
    a = '0; b = '0; l_in = 1'b0; e_in = 1'b1; g_in = 1'b0; a8 = '0; b8 = '0;
    t_reset;
    t_above;
    t_below;
    t_onehot;
    t_eq_dom;
    t_odd_patterns;
    t_flips;
    t_reg_reset_collision;
    t_chain;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule